// File: doc/BRIEF.md
# Cascadable Paired Timer/Counter

This block holds two 16-bit count channels, A and B, behind a small word-addressed register bus. Each channel counts in one of two ways. In timer mode it counts every module clock. In counter mode it counts qualified activity on its own external input. A channel counts up or down. When it wraps, it either reloads and carries on, or reloads and stops. A wrap marks an interrupt as pending for that channel. An enable bit lets the pending flag reach the channel's interrupt line, and writing a one to the status register clears it.

Setting the extend bit in channel A's control register joins the two channels into one 32-bit counter. A's run, control and reload registers then drive the whole pair. A carry or borrow out of A steps B, and the 32-bit count reads back through A's count address. Channel B never raises an interrupt in this mode.

The external input passes through a qualifier. It goes through a two-flop synchronizer unless the control register marks the input as already synchronous. An optional inversion follows. A selector then counts either the level itself or its rising, falling or both edges.

Top module: `pair_timer`

## Requirements
- R1: After reset every register reads zero, both counts read zero, and irq_o is 0. The register map by word address is: 0 control A, 1 control B, 2 run A, 3 run B, 4 reload A, 5 reload B, 6 count A, 7 count B, 8 interrupt enable, 9 interrupt status. Run registers read back as zero.
- R2: Control bit1=0 selects down counting. A running channel steps once per qualified tick. A step taken from zero loads the reload value on that same edge and sets the pending flag.
- R3: Control bit1=1 selects up counting. A step taken from all-ones loads the reload value on that edge and sets the pending flag.
- R4: With control bit3=1 (one-shot), a wrap loads the reload value, clears the running state and sets the pending flag. After that the count holds.
- R5: The run register acts on three bits. Bit0 sets the running state and bit1 clears it, with bit1 winning when both are written. Bit2 loads the reload value into the count. Bits 2 and 0 together start from the reload value. Bit0 alone resumes from the held count. Control bit0 reads back the running state, and a channel that is not running does not count.
- R6: A write to a reload register leaves the running count alone until the next load or wrap.
- R7: Source select. In timer mode (control bit2=0), bit9=1 counts the qualified external input and bit9=0 counts every clock. In counter mode (bit2=1) the sense is inverted: bit10=0 counts the external input and bit10=1 counts every clock.
- R8: Control bits 7:6 select the qualification of the external input: 00 counts each clock the input is high, 01 rising edges, 10 falling edges, 11 both edges. Control bit5 inverts the input before qualification, so mode 00 with bit5 set counts low clocks.
- R9: With control bit8=0 the input passes a two-flop synchronizer. A rising input then counts on the third clock edge after it rises. With bit8=1 it counts on the first clock edge.
- R10: Control A bit4 joins the pair into one 32-bit counter run by A's registers. A write to reload A then sets both halves from the 32-bit data. Count A reads the 32-bit value, and B steps on A's carry or borrow. Only a full 32-bit wrap sets the pending flag, which goes on bit 0, and B's pending flag stays clear.
- R11: Pending flags sit at status bit index 0 for A and 1 for B. irq_o[i] is high only when pending bit i and enable bit i (enable register, same index) are both 1.
- R12: Writing 1 to a status bit clears that pending flag. Writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| ext_a_i | input | 1 | External count input of channel A |
| ext_b_i | input | 1 | External count input of channel B |
| irq_o | output | 2 | Interrupt requests, bit 0 channel A, bit 1 channel B |

## Verification
The count is visible on the bus in the cycle after every edge. A wrong step, a missed load or a wrong wrap point therefore shows up in the next count read. A wrong reload value first appears on the edge where the wrap happens, so the checks sample exactly on that edge and on the one before it. A faulty qualifier or synchronizer stage changes the number of ticks taken over a fixed input pattern, and a wrong synchronizer depth moves the first tick by one edge. A broken running state or pending flag appears within one cycle in control bit0, the status register or irq_o.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CTRL_W = 11;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_RUN  = 4'h2;
  localparam logic [ADDR_W-1:0] A_RLD  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h6;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'h8;
  localparam logic [ADDR_W-1:0] A_IST  = 4'h9;

  localparam int unsigned C_UP   = 1;
  localparam int unsigned C_CNT  = 2;
  localparam int unsigned C_ONCE = 3;
  localparam int unsigned C_EXT  = 4;
  localparam int unsigned C_INV  = 5;
  localparam int unsigned C_EDGE = 6;
  localparam int unsigned C_SYNC = 8;
  localparam int unsigned C_TSRC = 9;
  localparam int unsigned C_CSRC = 10;

  localparam int unsigned R_SET = 0;
  localparam int unsigned R_CLR = 1;
  localparam int unsigned R_LD  = 2;
endpackage

// File: rtl/tcp_qualifier.sv
module tcp_qualifier (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic       bypass_i,
  input  logic       inv_i,
  input  logic [1:0] mode_i,
  output logic       tick_o
);
  logic s1_q, s2_q, prev_q, lvl;

  assign lvl = (bypass_i ? sig_i : s2_q) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= sig_i;
      s2_q   <= s1_q;
      prev_q <= lvl;
    end
  end

  always_comb begin
    case (mode_i)
      2'b00:   tick_o = lvl;
      2'b01:   tick_o = lvl & ~prev_q;
      2'b10:   tick_o = ~lvl & prev_q;
      default: tick_o = lvl ^ prev_q;
    endcase
  end
endmodule

// File: rtl/tcp_counter.sv
module tcp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         up_i,
  output logic [W-1:0] cnt_o,
  output logic         at_end_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= up_i ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  assign cnt_o    = cnt_q;
  // last value before a wrap in the current direction
  assign at_end_o = up_i ? &cnt_q : ~|cnt_q;
endmodule

// File: rtl/pair_timer.sv
module pair_timer
  import tcp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2*CW-1:0]   wdata_i,
  output logic [2*CW-1:0]   rdata_o,
  input  logic              ext_a_i,
  input  logic              ext_b_i,
  output logic [1:0]        irq_o
);
  localparam int unsigned DW = 2 * CW;

  logic [CTRL_W-1:0] ctrl_q [2];
  logic [CW-1:0]     reload_q [2];
  logic [CW-1:0]     cnt_w [2];
  logic [1:0] run_q, pend_q, ien_q;
  logic [1:0] raw_w, qual_w, end_w, tick_w, up_w, load_w, wrap_w;
  logic [1:0] set_cmd, clr_cmd, ld_cmd, ext_in;
  logic       ext_mode, wrap_a_cas;

  assign ext_in   = {ext_b_i, ext_a_i};
  assign ext_mode = ctrl_q[0][C_EXT];

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic run_wr, use_ext;
    assign run_wr     = wr_en_i && (addr_i == A_RUN + ADDR_W'(c));
    assign set_cmd[c] = run_wr & wdata_i[R_SET];
    assign clr_cmd[c] = run_wr & wdata_i[R_CLR];
    assign ld_cmd[c]  = run_wr & wdata_i[R_LD];

    tcp_qualifier u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sig_i   (ext_in[c]),
      .bypass_i(ctrl_q[c][C_SYNC]),
      .inv_i   (ctrl_q[c][C_INV]),
      .mode_i  (ctrl_q[c][C_EDGE+1:C_EDGE]),
      .tick_o  (qual_w[c])
    );

    // counter mode uses an inverted source select
    assign use_ext  = ctrl_q[c][C_CNT] ? ~ctrl_q[c][C_CSRC] : ctrl_q[c][C_TSRC];
    assign raw_w[c] = use_ext ? qual_w[c] : 1'b1;

    tcp_counter #(.W(CW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_w[c]),
      .load_val_i(reload_q[c]),
      .step_i    (tick_w[c]),
      .up_i      (up_w[c]),
      .cnt_o     (cnt_w[c]),
      .at_end_o  (end_w[c])
    );
  end

  // pairing: B follows A's run state, direction and loads when extended
  assign wrap_a_cas = run_q[0] & raw_w[0] & end_w[0];
  assign up_w[0]    = ctrl_q[0][C_UP];
  assign up_w[1]    = ext_mode ? ctrl_q[0][C_UP] : ctrl_q[1][C_UP];
  assign tick_w[0]  = run_q[0] & raw_w[0];
  assign tick_w[1]  = ext_mode ? wrap_a_cas : (run_q[1] & raw_w[1]);
  assign wrap_w[0]  = wrap_a_cas & (~ext_mode | end_w[1]);
  assign wrap_w[1]  = ~ext_mode & run_q[1] & raw_w[1] & end_w[1];
  assign load_w[0]  = ld_cmd[0] | wrap_w[0];
  assign load_w[1]  = ext_mode ? (ld_cmd[0] | wrap_w[0]) : (ld_cmd[1] | wrap_w[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        ctrl_q[c]   <= '0;
        reload_q[c] <= '0;
      end
      run_q  <= '0;
      pend_q <= '0;
      ien_q  <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (clr_cmd[c])                              run_q[c] <= 1'b0;
        else if (set_cmd[c])                         run_q[c] <= 1'b1;
        else if (wrap_w[c] && ctrl_q[c][C_ONCE])     run_q[c] <= 1'b0;

        pend_q[c] <= wrap_w[c] |
                     (pend_q[c] & ~(wr_en_i && addr_i == A_IST && wdata_i[c]));

        if (wr_en_i && addr_i == A_CTRL + ADDR_W'(c)) begin
          ctrl_q[c]         <= wdata_i[CTRL_W-1:0];
          ctrl_q[c][0]      <= 1'b0;
          if (c == 1) ctrl_q[c][C_EXT] <= 1'b0;
        end
      end
      if (wr_en_i && addr_i == A_RLD) begin
        reload_q[0] <= wdata_i[CW-1:0];
        if (ext_mode) reload_q[1] <= wdata_i[DW-1:CW];
      end
      if (wr_en_i && addr_i == A_RLD + ADDR_W'(1)) reload_q[1] <= wdata_i[CW-1:0];
      if (wr_en_i && addr_i == A_IEN) ien_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:              rdata_o = DW'({ctrl_q[0][CTRL_W-1:1], run_q[0]});
      A_CTRL + 4'd1:       rdata_o = DW'({ctrl_q[1][CTRL_W-1:1], run_q[1]});
      A_RLD:               rdata_o = ext_mode ? {reload_q[1], reload_q[0]} : DW'(reload_q[0]);
      A_RLD + 4'd1:        rdata_o = DW'(reload_q[1]);
      A_CNT:               rdata_o = ext_mode ? {cnt_w[1], cnt_w[0]} : DW'(cnt_w[0]);
      A_CNT + 4'd1:        rdata_o = DW'(cnt_w[1]);
      A_IEN:               rdata_o = DW'(ien_q);
      A_IST:               rdata_o = DW'(pend_q);
      default:             rdata_o = '0;
    endcase
  end

  assign irq_o = pend_q & ien_q;
endmodule

// File: rtl/pair_timer_chk.sv
module pair_timer_chk
  import tcp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2*CW-1:0]   wdata_i,
  input logic [1:0]        run_q,
  input logic [1:0]        pend_q,
  input logic              ext_mode,
  input logic [CW-1:0]     cnt_a,
  input logic [CW-1:0]     reload_a
);
  assert_clr_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RUN && wdata_i[R_CLR]) |=> !run_q[0]);

  assert_load_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RUN && wdata_i[R_LD]) |=> cnt_a == $past(reload_a));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && !(wr_en_i && addr_i == A_RUN)) |=> $stable(cnt_a));

  assert_no_b_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode && !pend_q[1]) |=> !pend_q[1]);

  assert_pend_needs_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[0]) |-> $past(run_q[0]));
endmodule

bind pair_timer pair_timer_chk #(.CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .run_q   (run_q),
  .pend_q  (pend_q),
  .ext_mode(ext_mode),
  .cnt_a   (cnt_w[0]),
  .reload_a(reload_q[0])
);

// File: tb/pair_timer_test.sv
module pair_timer_test;
  import tcp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_a = 1'b0, ext_b = 1'b0;
  logic [1:0]  irq;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pair_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_a_i(ext_a), .ext_b_i(ext_b),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input int ch, input logic [31:0] ctrl, input logic [31:0] rl);
    wr(A_CTRL + 4'(ch), ctrl);
    wr(A_RLD + 4'(ch), rl);
    wr(A_RUN + 4'(ch), 32'h5);
  endtask

  task automatic t_reset;
    chk_reg("R1 ctrl A", A_CTRL, 0);
    chk_reg("R1 count A", A_CNT, 0);
    chk_reg("R1 reload B", A_RLD + 4'd1, 0);
    chk_reg("R1 status", A_IST, 0);
    chk("R1 irq", {30'b0, irq}, 0);
  endtask

  task automatic t_down;
    logic [31:0] d;
    start(0, 32'h0, 32'd3);
    chk_reg("R2 start value", A_CNT, 3);
    step(1);
    chk_reg("R2 step down", A_CNT, 2);
    step(3);
    chk_reg("R2 reload on wrap", A_CNT, 3);
    chk_reg("R2 pending", A_IST, 1);
    rd(A_CTRL, d);
    chk("R2 still running", d[0], 1);
    wr(A_RUN, 32'h2);
    wr(A_IST, 32'h1);
    chk_reg("R12 w1c clears", A_IST, 0);
    // one-shot down
    start(0, 32'h8, 32'd2);
    step(3);
    chk_reg("R4 reload after stop", A_CNT, 2);
    rd(A_CTRL, d);
    chk("R4 stopped", d[0], 0);
    chk_reg("R4 pending", A_IST, 1);
    step(2);
    chk_reg("R4 count holds", A_CNT, 2);
    wr(A_IST, 32'h1);
  endtask

  task automatic t_up;
    logic [31:0] d;
    start(0, 32'h2, 32'hFFFD);
    step(2);
    chk_reg("R3 at all-ones", A_CNT, 32'hFFFF);
    chk_reg("R3 no early pend", A_IST, 0);
    step(1);
    chk_reg("R3 reload on wrap", A_CNT, 32'hFFFD);
    chk_reg("R3 pending", A_IST, 1);
    wr(A_RUN, 32'h2);
    wr(A_IST, 32'h1);
    start(0, 32'hA, 32'hFFFE);
    step(2);
    chk_reg("R4 up one-shot reload", A_CNT, 32'hFFFE);
    rd(A_CTRL, d);
    chk("R4 up one-shot stopped", d[0], 0);
    wr(A_IST, 32'h1);
  endtask

  task automatic t_run;
    logic [31:0] d;
    start(1, 32'h0, 32'd100);
    step(5);
    chk_reg("R5 running", A_CNT + 4'd1, 95);
    wr(A_RUN + 4'd1, 32'h2);
    step(3);
    chk_reg("R5 stopped holds", A_CNT + 4'd1, 94);
    wr(A_RUN + 4'd1, 32'h1);
    step(2);
    chk_reg("R5 resume no reload", A_CNT + 4'd1, 92);
    wr(A_RUN + 4'd1, 32'h3);
    rd(A_CTRL + 4'd1, d);
    chk("R5 clear beats set", d[0], 0);
    wr(A_RUN + 4'd1, 32'h4);
    chk_reg("R5 load only", A_CNT + 4'd1, 100);
    wr(A_RUN + 4'd1, 32'h5);
    step(2);
    wr(A_RLD + 4'd1, 32'd50);
    step(1);
    chk_reg("R6 reload write deferred", A_CNT + 4'd1, 96);
    wr(A_RUN + 4'd1, 32'h5);
    chk_reg("R6 new reload used", A_CNT + 4'd1, 50);
    wr(A_RUN + 4'd1, 32'h2);
  endtask

  task automatic t_source;
    start(0, 32'h300, 32'd10);
    step(3);
    chk_reg("R7 timer ext low no count", A_CNT, 10);
    ext_a = 1'b1;
    step(2);
    chk_reg("R7 timer ext high counts", A_CNT, 8);
    ext_a = 1'b0;
    wr(A_RUN, 32'h2);
    start(0, 32'h404, 32'd10);
    step(3);
    chk_reg("R7 counter internal source", A_CNT, 7);
    wr(A_RUN, 32'h2);
  endtask

  task automatic t_edges;
    int exp_tab [8] = '{4, 2, 1, 3, 2, 1, 2, 3};
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ctl;
      ctl = 32'h106 | (32'(i % 4) << 6) | ((i >= 4) ? 32'h20 : 32'h0);
      wr(A_CTRL + 4'd1, ctl);
      step(2);
      wr(A_RLD + 4'd1, 0);
      wr(A_RUN + 4'd1, 32'h5);
      ext_b = 1'b1; step(3);
      ext_b = 1'b0; step(2);
      ext_b = 1'b1; step(1);
      chk_reg($sformatf("R8 mode %0d inv %0d", i % 4, i / 4), A_CNT + 4'd1, 32'(exp_tab[i]));
      ext_b = 1'b0;
      wr(A_RUN + 4'd1, 32'h2);
      step(2);
    end
  endtask

  task automatic t_sync;
    start(1, 32'h46, 0);
    ext_b = 1'b1;
    step(2);
    chk_reg("R9 sync delay", A_CNT + 4'd1, 0);
    step(1);
    chk_reg("R9 counted third edge", A_CNT + 4'd1, 1);
    ext_b = 1'b0;
    step(3);
    wr(A_RUN + 4'd1, 32'h2);
  endtask

  task automatic t_cascade;
    wr(A_IST, 32'h3);
    wr(A_IEN, 32'h3);
    wr(A_CTRL, 32'h12);
    wr(A_RLD, 32'h0001_FFFE);
    wr(A_RUN, 32'h5);
    chk_reg("R10 32-bit load", A_CNT, 32'h0001_FFFE);
    step(2);
    chk_reg("R10 carry into B", A_CNT, 32'h0002_0000);
    chk_reg("R10 B half", A_CNT + 4'd1, 32'h2);
    wr(A_RLD, 32'hFFFF_FFFE);
    chk_reg("R10 reload read", A_RLD, 32'hFFFF_FFFE);
    wr(A_RUN, 32'h5);
    step(1);
    chk_reg("R10 below wrap", A_CNT, 32'hFFFF_FFFF);
    step(1);
    chk_reg("R10 32-bit wrap reload", A_CNT, 32'hFFFF_FFFE);
    chk_reg("R10 only A pending", A_IST, 1);
    chk("R10 irq A only", {30'b0, irq}, 1);
    wr(A_RUN, 32'h2);
    wr(A_CTRL, 0);
    wr(A_IST, 32'h3);
  endtask

  task automatic t_irq;
    wr(A_IEN, 0);
    start(0, 32'h8, 32'd1);
    step(2);
    chk_reg("R11 pend A", A_IST, 1);
    chk("R11 masked", {30'b0, irq}, 0);
    wr(A_IEN, 32'h1);
    chk("R11 enabled", {30'b0, irq}, 1);
    wr(A_IST, 32'h0);
    chk_reg("R12 write zero no effect", A_IST, 1);
    wr(A_IST, 32'h2);
    chk_reg("R12 other bit no effect", A_IST, 1);
    wr(A_IST, 32'h1);
    chk("R12 irq cleared", {30'b0, irq}, 0);
    wr(A_IEN, 32'h3);
    start(1, 32'h8, 32'd0);
    step(1);
    chk_reg("R11 B index 1", A_IST, 2);
    chk("R11 irq B", {30'b0, irq}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_down();
    t_up();
    t_run();
    t_source();
    t_edges();
    t_sync();
    t_cascade();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule